// File: doc/BRIEF.md
# Transmit Lane Framer with DC Balance and Deskew Training

This block sits on the transmit side of a wide source-synchronous link. On every rising clock edge it takes a 48-bit parallel word and cuts it into eight 6-bit slices, one for each data lane. A per-lane DC-balance encoder then sends each slice either as it is or inverted, and adds a seventh flag bit that records the choice. The result is a set of 7-bit lane symbols and a 7-bit clock-lane symbol. A downstream 7:1 shifter consumes these symbols, so each lane bit lasts one seventh of a clock period.

An active-low training request replaces every data lane with a fixed calibration symbol and switches the clock lane to a different pattern. The receiver uses these patterns to align its per-lane sampling strobes. While training is requested, input words are ignored and each encoder holds its running disparity, so that encoding continues seamlessly once the request is released. A flag reports when the request has been held long enough for calibration to complete. An active-low power-down input silences all outputs.

Top module: `lane_framer_tx`

## Requirements
- R1: Lane k (k = 0..7) takes `word_in[6k+5:6k]`, and its symbol appears on `lane_sym[7k+6:7k]`. Symbol bits 5:0 carry the slice and bit 6 carries the balance flag. All outputs are registered: the symbol for a word sampled at one rising edge is visible from that edge until the next one.
- R2: The slice disparity d is (number of ones minus number of zeros). The slice is sent inverted with flag 1 when the lane's running disparity is zero, when the running disparity is positive and d > 0, or when the running disparity is negative and d <= 0. In every other case it is sent unmodified with flag 0.
- R3: Each lane's running disparity starts at 0. On every encoded cycle it gains d - 1 if the slice was sent unmodified, and 1 - d if it was inverted. It is clamped to the range -6..+7.
- R4: When the training request is high and power is on, the clock-lane symbol is 1111000 (bit 6 down to bit 0) and `out_en` is 1.
- R5: On an edge that samples `train_req_n` low while power is on, every data lane symbol becomes 1111000 and `word_in` has no effect on any output.
- R6: On an edge that samples `train_req_n` low while power is on, the clock-lane symbol becomes 1111100.
- R7: Running disparity is held through training cycles. The first edge that samples the request high again encodes `word_in` starting from the held value.
- R8: `train_met` rises after 4 consecutive edges that sample the request low with power on. It stays high while the request stays low, and clears on the first edge that samples the request high.
- R9: An edge that samples `pdn_n` low drives all symbols to zero, `out_en` to 0 and `train_met` to 0. It also clears every running disparity and the training count. Power-down takes priority over training.
- R10: While `rst_n` is low, every output is zero and every disparity is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock; rising edge samples inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn_n | input | 1 | Power-down, active low |
| train_req_n | input | 1 | Deskew training request, active low |
| word_in | input | 48 | Parallel input word |
| lane_sym | output | 56 | Eight 7-bit data-lane symbols, lane k at bits 7k+6:7k |
| clk_sym | output | 7 | Clock-lane symbol |
| out_en | output | 1 | Outputs enabled (power on) |
| train_met | output | 1 | Training request held for the minimum length |

## Verification
An all-zeros word drives every lane's disparity from 0 to the +7 limit in one cycle. An all-ones word then pulls it back, which separates the positive, negative and zero branches of the inversion rule. A walking pattern in which each lane gets a distinct slice exposes a swapped or misaligned lane mapping. Random words mix every branch across all lanes. Training bursts of five cycles and of two cycles, with random words applied during them, tell apart a held disparity from a reset or a drifting one, and confirm the minimum-length flag. A power-down burst followed by data shows that the disparity restarts from zero.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int LANE_W = 6;
  localparam int SYM_W  = LANE_W + 1;
  localparam int RD_W   = 4;
  localparam int RD_MAX = 7;
  localparam int RD_MIN = -6;

  typedef logic signed [RD_W-1:0] rd_t;

  // number of ones in a lane slice
  function automatic int slice_ones(logic [LANE_W-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < LANE_W; i++) n += int'(v[i]);
    return n;
  endfunction

  // ones minus zeros
  function automatic int slice_disp(logic [LANE_W-1:0] v);
    return 2 * slice_ones(v) - LANE_W;
  endfunction

  // inversion decision from running and current disparity
  function automatic logic flip_needed(rd_t rd, int d);
    logic f;
    if (rd == 0)     f = 1'b1;
    else if (rd > 0) f = (d > 0);
    else             f = (d <= 0);
    return f;
  endfunction

  // running disparity update with clamp
  function automatic rd_t rd_step(rd_t rd, int d, logic flip);
    int s;
    s = int'(rd) + (flip ? (1 - d) : (d - 1));
    if (s > RD_MAX) s = RD_MAX;
    if (s < RD_MIN) s = RD_MIN;
    return rd_t'(s);
  endfunction

  // symbol with n leading ones, MSB first
  function automatic logic [SYM_W-1:0] lead_ones(int n);
    logic [SYM_W-1:0] t;
    for (int i = 0; i < SYM_W; i++) t[SYM_W-1-i] = (i < n);
    return t;
  endfunction
endpackage

// File: rtl/lf_dc_encoder.sv
module lf_dc_encoder
  import lf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              hold,
  input  logic [LANE_W-1:0] din,
  input  logic [SYM_W-1:0]  train_sym,
  output logic [SYM_W-1:0]  sym,
  output rd_t               rd
);
  int                disp;
  logic              flip;
  logic [SYM_W-1:0]  enc_sym;
  rd_t               rd_nx;

  always_comb begin
    disp    = slice_disp(din);
    flip    = flip_needed(rd, disp);
    enc_sym = {flip, flip ? ~din : din};
    rd_nx   = rd_step(rd, disp, flip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym <= '0;
      rd  <= '0;
    end else if (!pwr_on) begin
      sym <= '0;
      rd  <= '0;
    end else if (hold) begin
      sym <= train_sym;
    end else begin
      sym <= enc_sym;
      rd  <= rd_nx;
    end
  end
endmodule

// File: rtl/lf_clk_lane.sv
module lf_clk_lane
  import lf_pkg::*;
#(
  parameter int NORM_ONES  = 4,
  parameter int TRAIN_ONES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             hold,
  output logic [SYM_W-1:0] clk_sym,
  output logic             out_en
);
  localparam logic [SYM_W-1:0] NORM_PAT  = lead_ones(NORM_ONES);
  localparam logic [SYM_W-1:0] TRAIN_PAT = lead_ones(TRAIN_ONES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sym <= '0;
      out_en  <= 1'b0;
    end else if (!pwr_on) begin
      clk_sym <= '0;
      out_en  <= 1'b0;
    end else begin
      clk_sym <= hold ? TRAIN_PAT : NORM_PAT;
      out_en  <= 1'b1;
    end
  end
endmodule

// File: rtl/lf_train_ctrl.sv
module lf_train_ctrl #(
  parameter int MIN_TRAIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  input  logic hold,
  output logic train_met
);
  localparam int CNT_W = $clog2(MIN_TRAIN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_TRAIN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!pwr_on || !hold)  cnt <= '0;
    else if (cnt != CNT_TOP)    cnt <= cnt + 1'b1;
  end

  assign train_met = (cnt == CNT_TOP);
endmodule

// File: rtl/lane_framer_tx.sv
module lane_framer_tx
  import lf_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int MIN_TRAIN  = 4,
  parameter int NORM_ONES  = 4,
  parameter int TRAIN_ONES = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pdn_n,
  input  logic                     train_req_n,
  input  logic [LANES*LANE_W-1:0]  word_in,
  output logic [LANES*SYM_W-1:0]   lane_sym,
  output logic [SYM_W-1:0]         clk_sym,
  output logic                     out_en,
  output logic                     train_met
);
  localparam logic [SYM_W-1:0] DATA_TRAIN_PAT = lead_ones(NORM_ONES);

  // named internal events
  logic                   pwr_on;
  logic                   hold_rd;
  logic [LANES*RD_W-1:0]  rd_bus;

  assign pwr_on  = pdn_n;
  assign hold_rd = ~train_req_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lf_dc_encoder u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_on    (pwr_on),
      .hold      (hold_rd),
      .din       (word_in[g*LANE_W +: LANE_W]),
      .train_sym (DATA_TRAIN_PAT),
      .sym       (lane_sym[g*SYM_W +: SYM_W]),
      .rd        (rd_bus[g*RD_W +: RD_W])
    );
  end

  lf_clk_lane #(
    .NORM_ONES  (NORM_ONES),
    .TRAIN_ONES (TRAIN_ONES)
  ) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_on  (pwr_on),
    .hold    (hold_rd),
    .clk_sym (clk_sym),
    .out_en  (out_en)
  );

  lf_train_ctrl #(
    .MIN_TRAIN (MIN_TRAIN)
  ) u_trn (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_on    (pwr_on),
    .hold      (hold_rd),
    .train_met (train_met)
  );
endmodule

// File: rtl/lf_checker.sv
module lf_checker
  import lf_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int NORM_ONES  = 4,
  parameter int TRAIN_ONES = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pdn_n,
  input logic                    train_req_n,
  input logic [LANES*SYM_W-1:0]  lane_sym,
  input logic [SYM_W-1:0]        clk_sym,
  input logic                    out_en,
  input logic                    train_met,
  input logic [LANES*RD_W-1:0]   rd_bus
);
  localparam logic [SYM_W-1:0] NPAT = lead_ones(NORM_ONES);
  localparam logic [SYM_W-1:0] TPAT = lead_ones(TRAIN_ONES);

  // R5
  train_lane_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_n && !train_req_n) |=> (lane_sym == {LANES{NPAT}}));

  // R6
  train_clk_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_n && !train_req_n) |=> (clk_sym == TPAT));

  // R4
  norm_clk_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_n && train_req_n) |=> (clk_sym == NPAT && out_en));

  // R9
  pdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_n |=> (!out_en && clk_sym == '0 && lane_sym == '0 && !train_met && rd_bus == '0));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_n && !train_req_n) |=> $stable(rd_bus));

  // R8
  met_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_req_n |=> !train_met);

  // R8
  met_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_met) |-> !$past(train_req_n));

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    // R3
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(rd_bus[g*RD_W +: RD_W]) >= RD_MIN) && ($signed(rd_bus[g*RD_W +: RD_W]) <= RD_MAX));
  end
endmodule

bind lane_framer_tx lf_checker #(
  .LANES      (LANES),
  .NORM_ONES  (NORM_ONES),
  .TRAIN_ONES (TRAIN_ONES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pdn_n       (pdn_n),
  .train_req_n (train_req_n),
  .lane_sym    (lane_sym),
  .clk_sym     (clk_sym),
  .out_en      (out_en),
  .train_met   (train_met),
  .rd_bus      (rd_bus)
);

// File: tb/tb_lane_framer_tx.sv
`timescale 1ns/1ps
module tb_lane_framer_tx;
  localparam int NL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pdn_n = 1'b1;
  logic        train_req_n = 1'b1;
  logic [47:0] word_in = '0;
  logic [55:0] lane_sym;
  logic [6:0]  clk_sym;
  logic        out_en;
  logic        train_met;

  always #2.5 clk = ~clk;

  lane_framer_tx dut (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .train_req_n(train_req_n),
    .word_in(word_in), .lane_sym(lane_sym), .clk_sym(clk_sym),
    .out_en(out_en), .train_met(train_met)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int          rd_m[NL];
  int          low_run;
  logic [55:0] exp_lane;
  logic [6:0]  exp_clk;
  logic        exp_en;
  logic        exp_met;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (!pdn_n) begin
      exp_lane = '0; exp_clk = '0; exp_en = 0; low_run = 0;
      foreach (rd_m[k]) rd_m[k] = 0;
    end else if (!train_req_n) begin
      for (int k = 0; k < NL; k++) exp_lane[7*k +: 7] = 7'b1111000;
      exp_clk = 7'b1111100; exp_en = 1;
      if (low_run < 4) low_run++;
    end else begin
      for (int k = 0; k < NL; k++) begin
        logic [5:0] x;
        int d;
        bit inv;
        x = word_in[6*k +: 6];
        d = 2 * $countones(x) - 6;
        inv = (rd_m[k] == 0) || (rd_m[k] > 0 && d > 0) || (rd_m[k] < 0 && d <= 0);
        exp_lane[7*k +: 7] = inv ? {1'b1, ~x} : {1'b0, x};
        rd_m[k] += inv ? (1 - d) : (d - 1);
        if (rd_m[k] > 7)  rd_m[k] = 7;
        if (rd_m[k] < -6) rd_m[k] = -6;
      end
      exp_clk = 7'b1111000; exp_en = 1; low_run = 0;
    end
    exp_met = (low_run == 4);
  endtask

  task automatic cycle(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    for (int k = 0; k < NL; k++)
      chk(lane_sym[7*k +: 7] == exp_lane[7*k +: 7], req, $sformatf("lane%0d", k),
          64'(lane_sym[7*k +: 7]), 64'(exp_lane[7*k +: 7]));
    chk(clk_sym == exp_clk, req, "clk_sym", 64'(clk_sym), 64'(exp_clk));
    chk(out_en == exp_en, req, "out_en", 64'(out_en), 64'(exp_en));
    chk(train_met == exp_met, req, "train_met", 64'(train_met), 64'(exp_met));
  endtask

  function automatic logic [47:0] rnd48();
    return {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
  endfunction

  initial begin
    foreach (rd_m[k]) rd_m[k] = 0;
    low_run = 0;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(lane_sym == '0, "R10", "lane_sym", 64'(lane_sym), 0);
    chk(clk_sym == '0 && !out_en && !train_met, "R10", "ctrl", {out_en, train_met, clk_sym}, 0);
    rst_n = 1'b1;

    // R2 R3: all zeros drives disparity to the upper clamp, then all ones
    word_in = '0;                      cycle("R2 R3");
    word_in = '1;                      cycle("R2 R3");
    word_in = '1;                      cycle("R2 R3");
    word_in = 48'h0;                   cycle("R2 R3");
    // R1: distinct slice per lane
    for (int s = 0; s < 6; s++) begin
      logic [47:0] w;
      for (int k = 0; k < NL; k++) w[6*k +: 6] = 6'((k * 7 + s * 5 + 1) % 64);
      word_in = w;                     cycle("R1");
    end
    word_in = 48'hAAAA_AAAA_AAAA;      cycle("R1 R2");
    word_in = 48'h5555_5555_5555;      cycle("R1 R2");
    // R4: normal clock lane with random data
    for (int i = 0; i < 20; i++) begin word_in = rnd48(); cycle("R4 R2 R3"); end

    // R5 R6 R8: training for 5 cycles, data changing underneath
    train_req_n = 1'b0;
    for (int i = 0; i < 5; i++) begin word_in = rnd48(); cycle("R5 R6 R8"); end
    // R7: resume from held disparity
    train_req_n = 1'b1;
    for (int i = 0; i < 6; i++) begin word_in = rnd48(); cycle("R7 R8"); end

    // R8: short training never sets the flag
    train_req_n = 1'b0;
    for (int i = 0; i < 2; i++) begin word_in = rnd48(); cycle("R8"); end
    train_req_n = 1'b1;
    for (int i = 0; i < 3; i++) begin word_in = rnd48(); cycle("R7"); end

    // R9: power down, also with training requested, then restart at zero disparity
    pdn_n = 1'b0;
    for (int i = 0; i < 3; i++) begin word_in = rnd48(); cycle("R9"); end
    train_req_n = 1'b0;
    for (int i = 0; i < 2; i++) begin word_in = rnd48(); cycle("R9"); end
    pdn_n = 1'b1; train_req_n = 1'b1;
    word_in = '0;                      cycle("R9 R3");
    for (int i = 0; i < 10; i++) begin word_in = rnd48(); cycle("R9 R1"); end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule